// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar date as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. It advances on a prescaled tick enable. Every `TICKS_PER_HUND` pulses of `tick_en` add one hundredth of a second, and the carry ripples up through the calendar in the same clock cycle. Months have their proper lengths. February gets a 29th day in every year whose two-digit value is divisible by four.

A serial transfer engine sits beside the block. It reads all eight bytes at once from `time_q` and can overwrite all of them in a single cycle through `ld_en`/`ld_data`. The hours byte selects either a 24-hour or a 12-hour format, and in 12-hour mode it carries an AM/PM flag. The day byte also holds two control bits. One stops the count. The other decides whether the external transfer-reset input may raise `abort_req` toward the transfer engine.

Top module: `rtc_bcd_core`

## Requirements
- R1: After `rst`, `time_q` holds 64'h0001_0131_0000_0000: 00.00 s, 00:00 in 24-hour mode, day 1 with both control bits set, date 01, month 01, year 00. `abort_req` is 0.
- R2: Byte k of `time_q` is bits [8k+7:8k], with k = 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A cycle with `ld_en` high stores `ld_data` masked by 64'hFF1F_3F37_BF7F_7FFF, which is visible on the next cycle, so unused bit positions always read 0.
- R3: One hundredth step happens on the clock edge of the `TICKS_PER_HUND`-th `tick_en` pulse. A load clears the pulse count, and a `tick_en` in the same cycle as `ld_en` is not counted.
- R4: Hundredths wrap 99 to 00, and seconds and minutes wrap 59 to 00. Each wrap carries into the next byte.
- R5: When hours bit 7 is 0 (24-hour mode), bits 5:0 hold BCD 00 to 23, with bit 5 worth 20 hours. Going from 23 to 00 carries into the day and date.
- R6: When hours bit 7 is 1 (12-hour mode), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 12, 01 … 11. The step from 11 to 12 toggles PM, and from 11 PM to 12 AM the step carries into the day and date.
- R7: Day of week (bits 2:0) runs 1 to 7 and wraps to 1 on each day carry. Bits 5:4 keep their values.
- R8: On a day carry, a date equal to the month length returns to 01 and increments the month; otherwise the date increments. Months 04, 06, 09 and 11 have 30 days, February has 28 days, or 29 when the year value mod 4 is 0, and the rest have 31.
- R9: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R10: While day bit 5 is 1, `time_q` does not change except by load, and ticks are not counted.
- R11: `abort_req` is a registered copy of (day bit 4 == 0 AND `xfer_rst_n` == 0), valid one cycle after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler tick enable |
| ld_en | input | 1 | Load all eight registers this cycle |
| ld_data | input | 64 | Register image to load, byte k = register k |
| xfer_rst_n | input | 1 | External transfer reset, active low |
| time_q | output | 64 | Current register image, byte k = register k |
| abort_req | output | 1 | Registered transfer-abort request |

## Verification
A load shows on `time_q` one clock after the `ld_en` cycle. A time step shows one clock after the `tick_en` cycle that completes the prescale count, and `abort_req` follows `xfer_rst_n` by one clock. The bench drives every input on a falling edge and samples on the next falling edge, after exactly one rising edge. Expected images come from integer arithmetic in the bench, converted to BCD. The sweeps cover all month and year pairs at month end, every hour in both formats, and a full minute of hundredths.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NREG = 8;
  localparam int RW   = 8;
  localparam int IW   = NREG * RW;

  localparam int IDX_HUND = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HOUR = 3;
  localparam int IDX_DAY  = 4;
  localparam int IDX_DATE = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YEAR = 7;

  localparam logic [IW-1:0] REG_MASK    = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [IW-1:0] RESET_IMAGE = 64'h0001_0131_0000_0000;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] wrap_top(input int idx);
    if (idx == IDX_HUND) return 8'h99;
    else                 return 8'h59;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [4:0] sum;
    logic       leap;
    sum  = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    leap = (sum[1:0] == 2'b00);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clear,
  input  logic hold,
  output logic step
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          live;

  assign live = tick_en && !clear && !hold;
  assign step = live && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (step)     cnt <= '0;
    else if (live)     cnt <= cnt + CW'(1);
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
  a_r10_hold_cnt: assert property (@(posedge clk) disable iff (rst)
    (hold && !clear) |=> $stable(cnt));
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter logic [7:0] TOP = 8'h59
) (
  input  logic [7:0] cur,
  input  logic       en,
  output logic [7:0] nxt,
  output logic       carry
);
  import rtc_cal_pkg::*;
  logic at_top;
  assign at_top = (cur == TOP);
  assign carry  = en && at_top;
  always_comb begin
    if (!en)        nxt = cur;
    else if (at_top) nxt = 8'h00;
    else            nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [7:0] cur,
  input  logic       en,
  output logic [7:0] nxt,
  output logic       day_carry
);
  import rtc_cal_pkg::*;
  logic       mode12;
  logic       pm;
  logic [7:0] h12;
  logic [7:0] h24;

  assign mode12 = cur[7];
  assign pm     = cur[5];
  assign h12    = {3'b000, cur[4:0]};
  assign h24    = {2'b00, cur[5:0]};

  always_comb begin
    nxt       = cur;
    day_carry = 1'b0;
    if (en) begin
      if (!mode12) begin
        if (h24 == 8'h23) begin
          nxt       = 8'h00;
          day_carry = 1'b1;
        end else begin
          nxt = {2'b00, bcd_inc(h24)[5:0]};
        end
      end else begin
        if (h12 == 8'h12) begin
          nxt = {1'b1, 1'b0, pm, 5'h01};
        end else if (h12 == 8'h11) begin
          nxt       = {1'b1, 1'b0, !pm, 5'h12};
          day_carry = pm;
        end else begin
          nxt = {1'b1, 1'b0, pm, bcd_inc(h12)[4:0]};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step (
  input  logic [7:0] day_cur,
  input  logic [7:0] date_cur,
  input  logic [7:0] mon_cur,
  input  logic [7:0] year_cur,
  input  logic       en,
  output logic [7:0] day_nxt,
  output logic [7:0] date_nxt,
  output logic [7:0] mon_nxt,
  output logic       year_carry
);
  import rtc_cal_pkg::*;
  logic [7:0] last_date;
  logic [2:0] dow_nxt;

  assign last_date = month_len(mon_cur, year_cur);
  assign dow_nxt   = (day_cur[2:0] == 3'd7) ? 3'd1 : day_cur[2:0] + 3'd1;

  always_comb begin
    day_nxt    = day_cur;
    date_nxt   = date_cur;
    mon_nxt    = mon_cur;
    year_carry = 1'b0;
    if (en) begin
      day_nxt = {day_cur[7:3], dow_nxt};
      if (date_cur == last_date) begin
        date_nxt = 8'h01;
        if (mon_cur == 8'h12) begin
          mon_nxt    = 8'h01;
          year_carry = 1'b1;
        end else begin
          mon_nxt = bcd_inc(mon_cur);
        end
      end else begin
        date_nxt = bcd_inc(date_cur);
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core #(
  parameter int TICKS_PER_HUND = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        ld_en,
  input  logic [63:0] ld_data,
  input  logic        xfer_rst_n,
  output logic [63:0] time_q,
  output logic        abort_req
);
  import rtc_cal_pkg::*;
  localparam int NFAST = 3;

  logic             step;
  logic             osc_off;
  logic             rst_ignore;
  logic [7:0]       cur [NREG];
  logic [7:0]       nxt [NREG];
  logic [NFAST:0]   chain;
  logic             day_cy;
  logic             year_cy;
  logic             year_wrap_cy;
  logic [IW-1:0]    next_img;

  assign osc_off    = time_q[IDX_DAY*RW + 5];
  assign rst_ignore = time_q[IDX_DAY*RW + 4];

  rtc_tick_div #(.TICKS(TICKS_PER_HUND)) u_div (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .clear(ld_en), .hold(osc_off), .step(step)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_slice
      assign cur[gi]              = time_q[gi*RW +: RW];
      assign next_img[gi*RW +: RW] = nxt[gi];
    end
  endgenerate

  assign chain[0] = step;
  generate
    for (gi = 0; gi < NFAST; gi++) begin : g_fast
      rtc_bcd_wrap #(.TOP(wrap_top(gi))) u_wrap (
        .cur(cur[gi]), .en(chain[gi]), .nxt(nxt[gi]), .carry(chain[gi+1])
      );
    end
  endgenerate

  rtc_hour_step u_hour (
    .cur(cur[IDX_HOUR]), .en(chain[NFAST]),
    .nxt(nxt[IDX_HOUR]), .day_carry(day_cy)
  );

  rtc_date_step u_date (
    .day_cur(cur[IDX_DAY]), .date_cur(cur[IDX_DATE]),
    .mon_cur(cur[IDX_MON]), .year_cur(cur[IDX_YEAR]), .en(day_cy),
    .day_nxt(nxt[IDX_DAY]), .date_nxt(nxt[IDX_DATE]),
    .mon_nxt(nxt[IDX_MON]), .year_carry(year_cy)
  );

  rtc_bcd_wrap #(.TOP(8'h99)) u_year (
    .cur(cur[IDX_YEAR]), .en(year_cy), .nxt(nxt[IDX_YEAR]), .carry(year_wrap_cy)
  );

  always_ff @(posedge clk) begin
    if (rst)        time_q <= RESET_IMAGE;
    else if (ld_en) time_q <= ld_data & REG_MASK;
    else if (step)  time_q <= next_img;
  end

  always_ff @(posedge clk) begin
    if (rst) abort_req <= 1'b0;
    else     abort_req <= !rst_ignore && !xfer_rst_n;
  end

  a_r2_load_image: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (time_q == ($past(ld_data) & REG_MASK)));
  a_r2_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (time_q & ~REG_MASK) == '0);
  a_r10_osc_hold: assert property (@(posedge clk) disable iff (rst)
    (osc_off && !ld_en) |=> $stable(time_q));
  a_r4_hund_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && cur[IDX_HUND] == 8'h99) |=> (time_q[7:0] == 8'h00));
  a_r5_hour24_range: assert property (@(posedge clk) disable iff (rst)
    (step && !cur[IDX_HOUR][7] && cur[IDX_HOUR][5:0] <= 6'h23)
      |=> (time_q[IDX_HOUR*RW +: 6] <= 6'h23));
  a_r11_abort: assert property (@(posedge clk) disable iff (rst)
    (!rst_ignore && !xfer_rst_n) |=> abort_req);
  a_r9_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && year_wrap_cy) |=> (time_q[IDX_YEAR*RW +: RW] == 8'h00));
endmodule

// File: tb/rtc_bcd_core_tb_top.sv
module rtc_bcd_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        ld_en = 1'b0;
  logic [63:0] ld_data = '0;
  logic        xfer_rst_n = 1'b1;
  logic [63:0] time_q;
  logic        abort_req;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_bcd_core dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld_en(ld_en),
    .ld_data(ld_data), .xfer_rst_n(xfer_rst_n),
    .time_q(time_q), .abort_req(abort_req)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [63:0] img(input logic [7:0] yr, mo, dt, dy, hr, mi, se, hu);
    return {yr, mo, dt, dy, hr, mi, se, hu};
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr12(input int h);
    int v;
    v = (h % 12 == 0) ? 12 : h % 12;
    return 8'h80 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(v);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk); ld_en = 1'b1; ld_data = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset image", time_q, 64'h0001_0131_0000_0000);
    chk("R1 abort low", {63'd0, abort_req}, 64'd0);

    // R2 masking of unused bits
    load('1);
    chk("R2 mask", time_q, 64'hFF1F_3F37_BF7F_7FFF);

    // R3 prescale phase and load priority
    base = img(8'h24, 8'h03, 8'h10, 8'h02, 8'h08, 8'h30, 8'h15, 8'h40);
    load(base);
    tick(1);
    chk("R3 one tick no step", time_q, base);
    load(base);
    tick(1);
    chk("R3 phase cleared by load", time_q, base);
    tick(1);
    chk("R3 step after full count", time_q, base + 64'h1);
    @(negedge clk); ld_en = 1'b1; ld_data = base; tick_en = 1'b1;
    @(negedge clk); ld_en = 1'b0; tick_en = 1'b0;
    tick(1);
    chk("R3 tick in load cycle ignored", time_q, base);
    tick(1);
    chk("R3 step after load cycle", time_q, base + 64'h1);

    // R10 oscillator stop
    base = img(8'h24, 8'h03, 8'h10, 8'h21, 8'h08, 8'h30, 8'h15, 8'h40);
    load(base);
    tick(10);
    chk("R10 stopped", time_q, base);
    load(img(8'h24, 8'h03, 8'h10, 8'h01, 8'h08, 8'h30, 8'h15, 8'h40));
    tick(2);
    chk("R10 running again", time_q, img(8'h24, 8'h03, 8'h10, 8'h01, 8'h08, 8'h30, 8'h15, 8'h41));

    // R11 abort request
    @(negedge clk); xfer_rst_n = 1'b0;
    @(negedge clk);
    chk("R11 abort raised", {63'd0, abort_req}, 64'd1);
    xfer_rst_n = 1'b1;
    @(negedge clk);
    chk("R11 abort cleared", {63'd0, abort_req}, 64'd0);
    load(img(8'h24, 8'h03, 8'h10, 8'h11, 8'h08, 8'h30, 8'h15, 8'h40));
    xfer_rst_n = 1'b0;
    @(negedge clk);
    chk("R11 abort masked", {63'd0, abort_req}, 64'd0);
    xfer_rst_n = 1'b1;

    // R4 a full minute of hundredths
    load(img(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    for (int t = 1; t <= 6000; t++) begin
      tick(2);
      chk("R4 hundredths chain", time_q,
          img(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, bcd(t / 6000), bcd((t / 100) % 60), bcd(t % 100)));
    end

    // R5 and R6 every hour, both formats
    for (int h = 0; h < 24; h++) begin
      int hn;
      logic [7:0] dy, dt;
      hn = (h + 1) % 24;
      dy = (h == 23) ? 8'h04 : 8'h03;
      dt = (h == 23) ? 8'h16 : 8'h15;
      load(img(8'h24, 8'h03, 8'h15, 8'h03, bcd(h), 8'h59, 8'h59, 8'h99));
      tick(2);
      chk("R5 hour 24h", time_q, img(8'h24, 8'h03, dt, dy, bcd(hn), 8'h00, 8'h00, 8'h00));
      load(img(8'h24, 8'h03, 8'h15, 8'h03, hr12(h), 8'h59, 8'h59, 8'h99));
      tick(2);
      chk("R6 hour 12h", time_q, img(8'h24, 8'h03, dt, dy, hr12(hn), 8'h00, 8'h00, 8'h00));
    end

    // R7 R8 R9 month end for every month and year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, mn, yn;
        d  = mlen(m, y);
        mn = (m == 12) ? 1 : m + 1;
        yn = (m == 12) ? (y + 1) % 100 : y;
        load(img(bcd(y), bcd(m), bcd(d - 1), 8'h06, 8'h23, 8'h59, 8'h59, 8'h99));
        tick(2);
        chk("R8 date before end", time_q, img(bcd(y), bcd(m), bcd(d), 8'h07, 8'h00, 8'h00, 8'h00, 8'h00));
        load(img(bcd(y), bcd(m), bcd(d), 8'h37 & 8'h07, 8'h23, 8'h59, 8'h59, 8'h99));
        tick(2);
        chk("R9 R7 month end", time_q, img(bcd(yn), bcd(mn), 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
      end
    end

    // R7 control bits kept across day carry
    load(img(8'h24, 8'h05, 8'h10, 8'h17, 8'h23, 8'h59, 8'h59, 8'h99));
    tick(2);
    chk("R7 ctrl kept", time_q, img(8'h24, 8'h05, 8'h11, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule